// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Engine

This block is the register file and control logic of one bus-master DMA channel that sits next to a SCSI protocol core. Software programs a start count, a start address and a start descriptor-list address, then writes a command word. A start command copies the three programmed values into working registers and enables the channel. An idle command disables it, and an abort command sends a one-cycle cancel pulse toward the core. The flush code is accepted and does nothing.

While the channel runs, the protocol core asks for bursts through a request handshake that carries a length and a direction. The engine refuses a burst whose direction disagrees with the command direction bit. For any other burst it grants the requested length cut down to the remaining working count, and it presents the working address in the same cycle. On the next clock edge it lowers the count and raises the address by the granted length. A command-complete input zeroes the count and raises the done flag.

The done, abort and error flags clear in one of two ways, chosen by a mode input: either by a write with ones in those bit positions, or as a side effect of reading the status word. A status read also shows the live core-interrupt input as an extra flag.

Top module: `bmdma_top`

## Requirements
- R1: After reset, the working address reads 0xFFFFFFFF and the working list address reads 0xFFFFFFFD. Every other register reads 0, and the transfer enable and abort outputs are low.
- R2: The start count (index 1), start address (index 2) and start list address (index 6) read back what was last written. Writes to the working count (3), working address (4) and working list address (7) leave them unchanged.
- R3: The command register (index 0) stores the written word, and bit 7 is the direction, with 1 meaning device to memory. A command write with bits [1:0]=3 (start) loads working count from start count, working address from start address and working list address from start list address. It also clears status bits [5:0] and raises transfer enable, all effective one cycle after the write.
- R4: A command write with bits [1:0]=0 (idle) lowers transfer enable, and 1 (flush) leaves it unchanged. A write with 2 (abort) leaves enable unchanged and raises the abort output for exactly the following cycle.
- R5: With the clear-on-read mode input low, a write to status (index 5) clears each of error (bit 1), abort (bit 2) and done (bit 3) whose written bit is 1. All other status bits stay as they are.
- R6: With the clear-on-read mode input high, writes to status have no effect. A status read returns the stored error, abort and done bits, and those three bits read as 0 from the next cycle on.
- R7: A status read shows bit 4 set whenever the core-interrupt input is high, in addition to the stored bits.
- R8: A burst request whose direction differs from command bit 7 is not acknowledged and changes neither the working count nor the working address.
- R9: An accepted burst is acknowledged in the same cycle with a granted length equal to the smaller of the requested length and the working count, and with the working address on the address output. On the next edge the working count drops by the granted length and the working address rises by it.
- R10: Command complete sets working count to 0 and status done (bit 3) one cycle later. This takes priority over a burst and over a start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (drives status clear-on-read) |
| regAddr | input | 3 | Register word index |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for regAddr, combinational |
| clrOnRead | input | 1 | 1: status flags clear on read, writes ignored; 0: write-one-to-clear |
| coreIrq | input | 1 | Interrupt level from the protocol core |
| cmdDone | input | 1 | Command-complete pulse from the protocol core |
| xferReq | input | 1 | Burst request |
| xferToMem | input | 1 | Burst direction, 1 = device to memory |
| xferLen | input | LEN_W | Requested burst length in bytes |
| xferAck | output | 1 | Burst accepted this cycle |
| xferGrantLen | output | LEN_W | Granted burst length |
| xferAddr | output | DATA_W | Memory address for the burst (working address) |
| xferEnable | output | 1 | Transfer enabled by start, cleared by idle |
| abortReq | output | 1 | One-cycle request to cancel the active core request |

## Verification
Read data, burst acknowledge, granted length and burst address are combinational. The bench checks them 1 ns after driving the inputs on the falling edge, in the same cycle. Register loads, count and address updates, flag changes and transfer enable take effect at the next rising edge, so the bench checks them by a read in a later cycle. The abort pulse is due exactly one cycle after the abort write, and a behavioural model compares it and transfer enable at every falling edge. The clear-on-read case needs two reads: the first must still show the old flags and only the second shows them cleared.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int NUM_REGS = 8;
  localparam int IDX_W = $clog2(NUM_REGS);

  localparam logic [IDX_W-1:0] IDX_CMD       = 3'd0;
  localparam logic [IDX_W-1:0] IDX_START_CNT = 3'd1;
  localparam logic [IDX_W-1:0] IDX_START_ADR = 3'd2;
  localparam logic [IDX_W-1:0] IDX_WORK_CNT  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_WORK_ADR  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_STATUS    = 3'd5;
  localparam logic [IDX_W-1:0] IDX_START_LST = 3'd6;
  localparam logic [IDX_W-1:0] IDX_WORK_LST  = 3'd7;

  localparam int CMD_DIR_BIT = 7;
  localparam int STS_W       = 6;
  localparam int STS_DONE    = 3;
  localparam int STS_CORE    = 4;
  localparam logic [STS_W-1:0] STS_CLR_MASK = 6'b001110;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dmaOp_e;

  typedef struct packed {
    logic wrCmd;
    logic wrStartCnt;
    logic wrStartAdr;
    logic wrStartLst;
    logic loadStart;
    logic stsW1c;
    logic stsRdClr;
    logic xferStep;
    logic doneSet;
  } strobe_t;
endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [IDX_W-1:0] regAddr,
  input  logic [1:0]       wrOp,
  input  logic             clrOnRead,
  input  logic             xferReq,
  input  logic             xferToMem,
  input  logic             cmdDir,
  input  logic             cmdDone,
  output strobe_t          strb,
  output logic             xferAck,
  output logic             xferEnable,
  output logic             abortReq
);
  logic enableQ;
  logic abortQ;

  always_comb begin
    strb            = '0;
    strb.wrCmd      = regWrEn && (regAddr == IDX_CMD);
    strb.wrStartCnt = regWrEn && (regAddr == IDX_START_CNT);
    strb.wrStartAdr = regWrEn && (regAddr == IDX_START_ADR);
    strb.wrStartLst = regWrEn && (regAddr == IDX_START_LST);
    strb.loadStart  = strb.wrCmd && (wrOp == OP_START);
    strb.stsW1c     = regWrEn && (regAddr == IDX_STATUS) && !clrOnRead;
    strb.stsRdClr   = regRdEn && (regAddr == IDX_STATUS) && clrOnRead;
    xferAck         = xferReq && (xferToMem == cmdDir);
    strb.xferStep   = xferAck;
    strb.doneSet    = cmdDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      abortQ  <= 1'b0;
    end else begin
      abortQ <= strb.wrCmd && (wrOp == OP_ABORT);
      if (strb.wrCmd && (wrOp == OP_IDLE)) enableQ <= 1'b0;
      else if (strb.loadStart)             enableQ <= 1'b1;
    end
  end

  assign xferEnable = enableQ;
  assign abortReq   = abortQ;
endmodule

// File: rtl/bmdma_dp.sv
module bmdma_dp
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic              coreIrq,
  input  logic [LEN_W-1:0]  xferLen,
  output logic [DATA_W-1:0] rdData,
  output logic [LEN_W-1:0]  grantLen,
  output logic [DATA_W-1:0] workAdr,
  output logic [DATA_W-1:0] workCnt,
  output logic              cmdDir,
  output logic [STS_W-1:0]  stsFlags
);
  localparam logic [DATA_W-1:0] ADR_RST = '1;
  localparam logic [DATA_W-1:0] LST_RST = ~DATA_W'(2);

  logic [DATA_W-1:0] cmdQ, startCntQ, startAdrQ, startLstQ;
  logic [DATA_W-1:0] workCntQ, workAdrQ, workLstQ;
  logic [STS_W-1:0]  stsQ, stsN;
  logic [DATA_W-1:0] grantWide;
  logic [STS_W-1:0]  stsView;

  always_comb begin
    if (DATA_W'(xferLen) > workCntQ) grantWide = workCntQ;
    else                             grantWide = DATA_W'(xferLen);
  end
  assign grantLen = grantWide[LEN_W-1:0];

  always_comb begin
    stsN = stsQ;
    if (strb.loadStart) stsN = '0;
    if (strb.stsW1c)    stsN = stsN & ~(wrData[STS_W-1:0] & STS_CLR_MASK);
    if (strb.stsRdClr)  stsN = stsN & ~STS_CLR_MASK;
    if (strb.doneSet)   stsN[STS_DONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ      <= '0;
      startCntQ <= '0;
      startAdrQ <= '0;
      startLstQ <= '0;
      workCntQ  <= '0;
      workAdrQ  <= ADR_RST;
      workLstQ  <= LST_RST;
      stsQ      <= '0;
    end else begin
      stsQ <= stsN;
      if (strb.wrCmd)      cmdQ      <= wrData;
      if (strb.wrStartCnt) startCntQ <= wrData;
      if (strb.wrStartAdr) startAdrQ <= wrData;
      if (strb.wrStartLst) startLstQ <= wrData;

      if (strb.doneSet)        workCntQ <= '0;
      else if (strb.loadStart) workCntQ <= startCntQ;
      else if (strb.xferStep)  workCntQ <= workCntQ - grantWide;

      if (strb.loadStart)     workAdrQ <= startAdrQ;
      else if (strb.xferStep) workAdrQ <= workAdrQ + grantWide;

      if (strb.loadStart) workLstQ <= startLstQ;
    end
  end

  always_comb begin
    stsView = stsQ;
    stsView[STS_CORE] = stsQ[STS_CORE] | coreIrq;
  end

  always_comb begin
    case (rdIdx)
      IDX_CMD:       rdData = cmdQ;
      IDX_START_CNT: rdData = startCntQ;
      IDX_START_ADR: rdData = startAdrQ;
      IDX_WORK_CNT:  rdData = workCntQ;
      IDX_WORK_ADR:  rdData = workAdrQ;
      IDX_STATUS:    rdData = DATA_W'(stsView);
      IDX_START_LST: rdData = startLstQ;
      default:       rdData = workLstQ;
    endcase
  end

  assign workAdr  = workAdrQ;
  assign workCnt  = workCntQ;
  assign cmdDir   = cmdQ[CMD_DIR_BIT];
  assign stsFlags = stsQ;
endmodule

// File: rtl/bmdma_top.sv
module bmdma_top
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              clrOnRead,
  input  logic              coreIrq,
  input  logic              cmdDone,
  input  logic              xferReq,
  input  logic              xferToMem,
  input  logic [LEN_W-1:0]  xferLen,
  output logic              xferAck,
  output logic [LEN_W-1:0]  xferGrantLen,
  output logic [DATA_W-1:0] xferAddr,
  output logic              xferEnable,
  output logic              abortReq
);
  strobe_t           strb;
  logic              cmdDir;
  logic [DATA_W-1:0] workCnt;
  logic [STS_W-1:0]  stsFlags;

  bmdma_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .wrOp       (regWrData[1:0]),
    .clrOnRead  (clrOnRead),
    .xferReq    (xferReq),
    .xferToMem  (xferToMem),
    .cmdDir     (cmdDir),
    .cmdDone    (cmdDone),
    .strb       (strb),
    .xferAck    (xferAck),
    .xferEnable (xferEnable),
    .abortReq   (abortReq)
  );

  bmdma_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWrData),
    .rdIdx    (regAddr),
    .coreIrq  (coreIrq),
    .xferLen  (xferLen),
    .rdData   (regRdData),
    .grantLen (xferGrantLen),
    .workAdr  (xferAddr),
    .workCnt  (workCnt),
    .cmdDir   (cmdDir),
    .stsFlags (stsFlags)
  );
endmodule

// File: rtl/bmdma_chk.sv
module bmdma_chk #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [2:0]        regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              clrOnRead,
  input logic              cmdDone,
  input logic              xferReq,
  input logic              xferToMem,
  input logic [LEN_W-1:0]  xferLen,
  input logic              xferAck,
  input logic [LEN_W-1:0]  xferGrantLen,
  input logic              xferEnable,
  input logic              abortReq,
  input logic              cmdDir,
  input logic [DATA_W-1:0] workCnt,
  input logic [5:0]        stsFlags
);
  logic              startWr, abortWr, stsWrIgnored;
  logic [DATA_W-1:0] grantExt;

  assign startWr      = regWrEn && (regAddr == 3'd0) && (regWrData[1:0] == 2'd3);
  assign abortWr      = regWrEn && (regAddr == 3'd0) && (regWrData[1:0] == 2'd2);
  assign stsWrIgnored = regWrEn && (regAddr == 3'd5) && clrOnRead && !regRdEn && !cmdDone;
  assign grantExt     = DATA_W'(xferGrantLen);

  a_r8_drop_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    xferReq && (xferToMem != cmdDir) |-> !xferAck);

  a_r9_grant_bound: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |-> (xferGrantLen <= xferLen) && (grantExt <= workCnt));

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rstN)
    xferAck && !cmdDone && !startWr |=> workCnt == $past(workCnt) - $past(grantExt));

  a_r10_done_set: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> (workCnt == '0) && stsFlags[3]);

  a_r4_abort_pulse: assert property (@(posedge clk) disable iff (!rstN)
    abortWr |=> abortReq);

  a_r4_abort_only: assert property (@(posedge clk) disable iff (!rstN)
    !abortWr |=> !abortReq);

  a_r3_start_enable: assert property (@(posedge clk) disable iff (!rstN)
    startWr && !cmdDone |=> xferEnable && (stsFlags == 6'd0));

  a_r6_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    stsWrIgnored |=> $stable(stsFlags));
endmodule

bind bmdma_top bmdma_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/bmdma_top_tb.sv
module bmdma_top_tb;
  localparam int DW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 0, regRdEn = 0, clrOnRead = 0, coreIrq = 0, cmdDone = 0;
  logic          xferReq = 0, xferToMem = 0;
  logic [2:0]    regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [LW-1:0] xferLen = '0;
  logic [DW-1:0] regRdData, xferAddr;
  logic [LW-1:0] xferGrantLen;
  logic          xferAck, xferEnable, abortReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  logic [31:0] m[8];
  bit mEn, mAbt;

  always #5 clk = ~clk;

  bmdma_top u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model update, inputs are stable at the rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) m[i] = 0;
      m[4] = 32'hFFFF_FFFF;
      m[7] = 32'hFFFF_FFFD;
      mEn = 0; mAbt = 0;
    end else begin
      logic [31:0] g, s;
      bit ack, wc, st;
      ack = xferReq && (xferToMem == m[0][7]);
      g   = (32'(xferLen) > m[3]) ? m[3] : 32'(xferLen);
      wc  = regWrEn && regAddr == 0;
      st  = wc && regWrData[1:0] == 3;
      s   = m[5];
      if (st) s = 0;
      if (regWrEn && regAddr == 5 && !clrOnRead) s = s & ~(regWrData & 32'h0E);
      if (regRdEn && regAddr == 5 && clrOnRead) s = s & ~32'h0E;
      if (cmdDone) s = s | 32'h08;
      mAbt = wc && regWrData[1:0] == 2;
      if (wc && regWrData[1:0] == 0) mEn = 0;
      else if (st) mEn = 1;
      if (cmdDone) m[3] = 0;
      else if (st) m[3] = m[1];
      else if (ack) m[3] = m[3] - g;
      if (st) begin m[4] = m[2]; m[7] = m[6]; end
      else if (ack) m[4] = m[4] + g;
      if (wc) m[0] = regWrData;
      if (regWrEn && regAddr inside {1, 2, 6}) m[regAddr] = regWrData;
      m[5] = s;
    end
  end

  // registered outputs compared every cycle
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R4 xferEnable", 32'(xferEnable), 32'(mEn));
      chk("R4 abortReq", 32'(abortReq), 32'(mAbt));
    end
  end

  task automatic endCycle();
    @(posedge clk); #1;
    regWrEn = 0; regRdEn = 0; xferReq = 0; cmdDone = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    endCycle();
  endtask

  task automatic rd(string tag, logic [2:0] a);
    logic [31:0] e;
    @(negedge clk); regRdEn = 1; regAddr = a; #1;
    e = m[a];
    if (a == 5 && coreIrq) e = e | 32'h10;
    chk(tag, regRdData, e);
    endCycle();
  endtask

  task automatic xfer(string tag, logic [15:0] len, bit toMem);
    bit ea; logic [31:0] g;
    @(negedge clk); xferReq = 1; xferLen = len; xferToMem = toMem; #1;
    ea = (toMem == m[0][7]);
    g  = (32'(len) > m[3]) ? m[3] : 32'(len);
    chk({tag, " ack"}, 32'(xferAck), 32'(ea));
    if (ea) begin
      chk({tag, " grant"}, 32'(xferGrantLen), g);
      chk({tag, " addr"}, xferAddr, m[4]);
    end
    endCycle();
  endtask

  task automatic pulseDone();
    @(negedge clk); cmdDone = 1;
    endCycle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset values
    for (int i = 0; i < 8; i++) rd("R1 reset read", 3'(i));
    chk("R1 enable at reset", 32'(xferEnable), 0);
    chk("R1 abort at reset", 32'(abortReq), 0);
    // R2 start registers read/write, working registers ignore writes
    wr(1, 32'h0000_0100); wr(2, 32'h0000_1000); wr(6, 32'h0000_2000);
    rd("R2 start count", 1); rd("R2 start addr", 2); rd("R2 start list", 6);
    wr(3, 32'h5); wr(4, 32'h6); wr(7, 32'h7);
    rd("R2 work count ignored", 3); rd("R2 work addr ignored", 4); rd("R2 work list ignored", 7);
    chk("R2 work addr held", xferAddr, 32'hFFFF_FFFF);
    // R3 start, direction memory to device
    wr(0, 32'h0000_0003);
    chk("R3 enable after start", 32'(xferEnable), 1);
    rd("R3 cmd readback", 0); rd("R3 work count load", 3);
    rd("R3 work addr load", 4); rd("R3 work list load", 7); rd("R3 status cleared", 5);
    // R9 accepted burst
    xfer("R9 burst 0x40", 16'h0040, 0);
    rd("R9 count after burst", 3); rd("R9 addr after burst", 4);
    // R8 mismatched direction dropped
    xfer("R8 wrong dir", 16'h0010, 1);
    rd("R8 count unchanged", 3); rd("R8 addr unchanged", 4);
    // R9 clipping and empty count
    xfer("R9 clipped", 16'h0200, 0);
    rd("R9 count zero", 3);
    xfer("R9 zero grant", 16'h0008, 0);
    // R10 command complete
    wr(0, 32'h0000_0003);
    pulseDone();
    rd("R10 count zeroed", 3); rd("R10 done set", 5);
    // R7 core interrupt shown on read
    coreIrq = 1; rd("R7 core irq in status", 5); coreIrq = 0;
    rd("R7 core irq gone", 5);
    // R5 write one to clear
    wr(5, 32'h0000_0002); rd("R5 done kept", 5);
    wr(5, 32'h0000_0008); rd("R5 done cleared", 5);
    // R6 clear on read mode
    pulseDone(); clrOnRead = 1;
    wr(5, 32'h0000_000E); rd("R6 write ignored, old value", 5);
    rd("R6 cleared by read", 5);
    clrOnRead = 0;
    // R4 flush, abort, idle
    wr(0, 32'h0000_0001); chk("R4 flush keeps enable", 32'(xferEnable), 1);
    @(negedge clk); regWrEn = 1; regAddr = 0; regWrData = 32'h0000_0002;
    endCycle();
    chk("R4 abort pulse", 32'(abortReq), 1);
    chk("R4 abort keeps enable", 32'(xferEnable), 1);
    @(posedge clk); #1;
    chk("R4 abort one cycle", 32'(abortReq), 0);
    wr(0, 32'h0000_0000); chk("R4 idle disables", 32'(xferEnable), 0);
    // R3 start with device-to-memory direction, R9 accepted
    wr(1, 32'h0000_0030); wr(2, 32'h8000_0000);
    pulseDone();
    wr(0, 32'h0000_0083);
    rd("R3 start clears done", 5);
    xfer("R8 dir mismatch to device", 16'h0004, 0);
    xfer("R9 to memory burst", 16'h0010, 1);
    rd("R9 addr after to memory", 4); rd("R9 count after to memory", 3);
    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule